// File: doc/BRIEF.md
# Bank-Switched Address Decoder

This block sits between an 8-bit microprocessor with a 16-bit address bus and a 17-bit flat memory. The flat memory holds 48 KB of RAM and 48 KB of ROM. The decoder also drives chip selects for a handful of memory-mapped devices in a 4 KB I/O window. These devices are a colour palette, an input port adapter, a sound port adapter, a block-copy engine's registers and battery-backed configuration RAM. Everything else in that window falls into a general I/O select.

The lowest 36 KB of the CPU space is shared by RAM and ROM. A single bank flag picks which one a read sees. Software sets the flag by writing a control address, and the flag is taken from bit 0 of the data written. While ROM is banked in, a write to the shared region is still sent to the RAM underneath rather than dropped. Software can therefore read code and tables from ROM while it updates the RAM beneath them.

Every output is registered. The result of an access presented in one cycle appears after the next rising clock edge.

Top module: `membank_decoder`

## Requirements
- R1: A synchronous active-high reset clears every select, the write enable and the flat address, and sets the bank flag to RAM (0). A write to 0xC900 made while reset is held leaves the flag at RAM.
- R2: Outputs are registered, so an access presented before a rising edge shows its result after that edge. A cycle with neither read nor write strobe gives all selects low and the write enable low.
- R3: CPU 0x9000–0xBFFF always selects memory at flat address equal to the CPU address. Writes there raise the write enable.
- R4: CPU 0xD000–0xFFFF always selects memory at flat address 0x10000 plus the CPU address. A write there selects memory with the write enable low.
- R5: For a read of 0x0000–0x8FFF, the flat address is the CPU address when the bank flag is 0. It is 0x10000 plus the CPU address when the flag is 1.
- R6: A write to 0x0000–0x8FFF always goes to flat address equal to the CPU address with the write enable high, whatever the bank flag.
- R7: Device selects are:
  - sel_pal for 0xC000–0xC00F
  - sel_in for 0xC804–0xC807
  - sel_snd for 0xC80C–0xC80F
  - sel_blit for 0xCA00–0xCA07
  - sel_cfg for 0xCC00–0xCFFF
- R8: Every other address in 0xC000–0xCBFF, 0xC900 included, raises sel_io.
- R9: A strobed access raises exactly one select. No I/O address raises the write enable.
- R10: Only a write to exactly 0xC900 changes the bank flag, loading it from data bit 0. Reads of 0xC900 and writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data (bit 0 feeds the bank flag) |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| mem_addr | output | 17 | Flat memory address, updated on memory accesses |
| mem_we | output | 1 | Flat memory write enable |
| sel_mem | output | 1 | Flat memory selected |
| sel_pal | output | 1 | Colour palette selected |
| sel_in | output | 1 | Input port adapter selected |
| sel_snd | output | 1 | Sound port adapter selected |
| sel_blit | output | 1 | Block-copy registers selected |
| sel_cfg | output | 1 | Configuration RAM selected |
| sel_io | output | 1 | Remaining game I/O selected |

## Verification
The only hidden state is the bank flag. A wrong flag shows up only on the next read of 0x0000–0x8FFF, where bit 16 of mem_addr comes out wrong one edge after that read. The bench therefore follows every flag change, and every write that must not change the flag, with a read of the shared region. A decode fault shows one edge after the access, as a wrong or doubled select or a write enable on an I/O address. The bench probes both edges of every device span and the gaps between spans.

// File: rtl/membank_pkg.sv
package membank_pkg;
  localparam int CPU_AW = 16;
  localparam int FLAT_W = 17;
  localparam int NUM_DEV = 7;
  localparam int NUM_SPAN = NUM_DEV - 1;

  typedef enum logic [2:0] {
    DEV_MEM  = 3'd0,
    DEV_PAL  = 3'd1,
    DEV_IN   = 3'd2,
    DEV_SND  = 3'd3,
    DEV_BLIT = 3'd4,
    DEV_CFG  = 3'd5,
    DEV_IO   = 3'd6
  } dev_e;

  typedef enum logic [1:0] {
    KIND_SHARED = 2'd0,
    KIND_RAM    = 2'd1,
    KIND_ROM    = 2'd2
  } kind_e;

  typedef struct packed {
    logic [CPU_AW-1:0] first;
    logic [CPU_AW-1:0] last;
  } span_t;
endpackage

// File: rtl/mb_region_decode.sv
module mb_region_decode
  import membank_pkg::*;
#(
  parameter logic [CPU_AW-1:0] PAL_FIRST  = 16'hC000,
  parameter logic [CPU_AW-1:0] PAL_LAST   = 16'hC00F,
  parameter logic [CPU_AW-1:0] IN_FIRST   = 16'hC804,
  parameter logic [CPU_AW-1:0] IN_LAST    = 16'hC807,
  parameter logic [CPU_AW-1:0] SND_FIRST  = 16'hC80C,
  parameter logic [CPU_AW-1:0] SND_LAST   = 16'hC80F,
  parameter logic [CPU_AW-1:0] BLIT_FIRST = 16'hCA00,
  parameter logic [CPU_AW-1:0] BLIT_LAST  = 16'hCA07,
  parameter logic [CPU_AW-1:0] CFG_FIRST  = 16'hCC00,
  parameter logic [CPU_AW-1:0] CFG_LAST   = 16'hCFFF,
  parameter logic [CPU_AW-1:0] IO_FIRST   = 16'hC000,
  parameter logic [CPU_AW-1:0] IO_LAST    = 16'hCBFF,
  parameter logic [CPU_AW-1:0] SHARED_LAST = 16'h8FFF,
  parameter logic [CPU_AW-1:0] RAM_LAST    = 16'hBFFF
) (
  input  logic [CPU_AW-1:0] addr,
  output dev_e              dev,
  output kind_e             kind
);
  // index order is priority order: lower index wins on overlap
  localparam span_t SPANS [NUM_SPAN] = '{
    '{first: PAL_FIRST,  last: PAL_LAST},
    '{first: IN_FIRST,   last: IN_LAST},
    '{first: SND_FIRST,  last: SND_LAST},
    '{first: BLIT_FIRST, last: BLIT_LAST},
    '{first: CFG_FIRST,  last: CFG_LAST},
    '{first: IO_FIRST,   last: IO_LAST}
  };

  logic [NUM_SPAN-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_SPAN; g++) begin : g_span
      assign hit[g] = (addr >= SPANS[g].first) && (addr <= SPANS[g].last);
    end
  endgenerate

  always_comb begin
    dev = DEV_MEM;
    for (int i = NUM_SPAN - 1; i >= 0; i--) begin
      if (hit[i]) dev = dev_e'(i + 1);
    end
  end

  always_comb begin
    if (addr <= SHARED_LAST)   kind = KIND_SHARED;
    else if (addr <= RAM_LAST) kind = KIND_RAM;
    else                       kind = KIND_ROM;
  end
endmodule

// File: rtl/mb_bank_latch.sv
module mb_bank_latch
  import membank_pkg::*;
#(
  parameter logic [CPU_AW-1:0] CTRL_ADDR = 16'hC900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] addr,
  input  logic              wr,
  input  logic              flag_in,
  output logic              bank_q
);
  always_ff @(posedge clk) begin
    if (rst)                            bank_q <= 1'b0;
    else if (wr && addr == CTRL_ADDR)   bank_q <= flag_in;
  end

  // R10: flag only moves on a write to the control address
  assert_bank_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr) && $past(addr) == CTRL_ADDR)) |-> $stable(bank_q));
endmodule

// File: rtl/mb_flat_map.sv
module mb_flat_map
  import membank_pkg::*;
#(
  parameter logic [FLAT_W-1:0] RAM_BASE = 17'h00000,
  parameter logic [FLAT_W-1:0] ROM_BASE = 17'h10000
) (
  input  logic [CPU_AW-1:0] addr,
  input  kind_e             kind,
  input  logic              bank,
  input  logic              is_wr,
  output logic [FLAT_W-1:0] flat,
  output logic              we_ok
);
  localparam int PAD = FLAT_W - CPU_AW;

  logic to_rom;
  logic [FLAT_W-1:0] wide;

  assign wide   = {{PAD{1'b0}}, addr};
  // writes to the shared region always land in RAM
  assign to_rom = (kind == KIND_ROM) || (kind == KIND_SHARED && bank && !is_wr);
  assign flat   = to_rom ? (ROM_BASE + wide) : (RAM_BASE + wide);
  assign we_ok  = is_wr && (kind != KIND_ROM);
endmodule

// File: rtl/membank_decoder.sv
module membank_decoder
  import membank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_BIT = 0,
  parameter logic [CPU_AW-1:0] BANK_CTRL   = 16'hC900,
  parameter logic [CPU_AW-1:0] SHARED_LAST = 16'h8FFF,
  parameter logic [CPU_AW-1:0] RAM_LAST    = 16'hBFFF,
  parameter logic [CPU_AW-1:0] ROM_FIRST   = 16'hD000,
  parameter logic [FLAT_W-1:0] RAM_BASE    = 17'h00000,
  parameter logic [FLAT_W-1:0] ROM_BASE    = 17'h10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [FLAT_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              sel_mem,
  output logic              sel_pal,
  output logic              sel_in,
  output logic              sel_snd,
  output logic              sel_blit,
  output logic              sel_cfg,
  output logic              sel_io
);
  dev_e              dev;
  kind_e             kind;
  logic              bank;
  logic [FLAT_W-1:0] flat;
  logic              we_ok;
  logic              access;
  logic              unused_wdata;

  logic [NUM_DEV-1:0] sel_q;
  logic [FLAT_W-1:0]  mem_addr_q;
  logic               mem_we_q;

  assign access       = cpu_rd || cpu_wr;
  assign unused_wdata = ^cpu_wdata;

  mb_region_decode #(
    .SHARED_LAST(SHARED_LAST),
    .RAM_LAST   (RAM_LAST)
  ) u_region (
    .addr(cpu_addr),
    .dev (dev),
    .kind(kind)
  );

  mb_bank_latch #(
    .CTRL_ADDR(BANK_CTRL)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .addr   (cpu_addr),
    .wr     (cpu_wr),
    .flag_in(cpu_wdata[BANK_BIT]),
    .bank_q (bank)
  );

  mb_flat_map #(
    .RAM_BASE(RAM_BASE),
    .ROM_BASE(ROM_BASE)
  ) u_map (
    .addr (cpu_addr),
    .kind (kind),
    .bank (bank),
    .is_wr(cpu_wr),
    .flat (flat),
    .we_ok(we_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      mem_addr_q <= '0;
      mem_we_q   <= 1'b0;
    end else begin
      sel_q    <= access ? (NUM_DEV'(1) << dev) : '0;
      mem_we_q <= access && (dev == DEV_MEM) && we_ok;
      if (access && dev == DEV_MEM) mem_addr_q <= flat;
    end
  end

  assign mem_addr = mem_addr_q;
  assign mem_we   = mem_we_q;
  assign sel_mem  = sel_q[DEV_MEM];
  assign sel_pal  = sel_q[DEV_PAL];
  assign sel_in   = sel_q[DEV_IN];
  assign sel_snd  = sel_q[DEV_SND];
  assign sel_blit = sel_q[DEV_BLIT];
  assign sel_cfg  = sel_q[DEV_CFG];
  assign sel_io   = sel_q[DEV_IO];

  // R9: one select per strobed access
  assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_rd || cpu_wr)) |->
      $countones({sel_io, sel_cfg, sel_blit, sel_snd, sel_in, sel_pal, sel_mem}) == 1);

  // R9: write enable only with the memory select
  assert_io_no_we_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sel_mem);

  // R2: idle cycle leaves everything quiet
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cpu_rd) && !$past(cpu_wr)) |->
      (!mem_we && $onehot0({sel_io, sel_cfg, sel_blit, sel_snd, sel_in, sel_pal, sel_mem})
       && !sel_mem && !sel_io));

  // R6: shared-region writes land in RAM
  assert_shared_write_ram_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_wr) && $past(cpu_addr) <= SHARED_LAST) |->
      (mem_we && sel_mem && mem_addr == RAM_BASE + {{(FLAT_W-CPU_AW){1'b0}}, $past(cpu_addr)}));

  // R4: fixed-ROM reads land in the ROM half
  assert_fixed_rom_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_rd) && !$past(cpu_wr) && $past(cpu_addr) >= ROM_FIRST) |->
      (sel_mem && !mem_we && mem_addr[FLAT_W-1]));
endmodule

// File: tb/membank_decoder_bench.sv
`timescale 1ns/1ps
module membank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [16:0] mem_addr;
  logic        mem_we;
  logic        sel_mem, sel_pal, sel_in, sel_snd, sel_blit, sel_cfg, sel_io;

  always #2 clk = ~clk;

  membank_decoder u_membank_decoder (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .mem_addr(mem_addr), .mem_we(mem_we),
    .sel_mem(sel_mem), .sel_pal(sel_pal), .sel_in(sel_in), .sel_snd(sel_snd),
    .sel_blit(sel_blit), .sel_cfg(sel_cfg), .sel_io(sel_io)
  );

  // bench select order: {io,cfg,blit,snd,in,pal,mem}
  localparam logic [6:0] S_MEM = 7'b0000001, S_PAL = 7'b0000010, S_IN = 7'b0000100,
                         S_SND = 7'b0001000, S_BLIT = 7'b0010000, S_CFG = 7'b0100000,
                         S_IO = 7'b1000000;

  typedef struct {
    string       tag;
    logic [6:0]  sel;
    logic        we;
    logic [16:0] addr;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic model_bank = 1'b0;

  function automatic logic [6:0] got_sel();
    return {sel_io, sel_cfg, sel_blit, sel_snd, sel_in, sel_pal, sel_mem};
  endfunction

  function automatic exp_t model(input logic [15:0] a, input logic rd, input logic wr,
                                 input string tag);
    exp_t e;
    e.tag = tag; e.we = 1'b0; e.addr = '0;
    if (!rd && !wr)                       e.sel = 7'b0;
    else if (a >= 16'hC000 && a <= 16'hC00F) e.sel = S_PAL;
    else if (a >= 16'hC804 && a <= 16'hC807) e.sel = S_IN;
    else if (a >= 16'hC80C && a <= 16'hC80F) e.sel = S_SND;
    else if (a >= 16'hCA00 && a <= 16'hCA07) e.sel = S_BLIT;
    else if (a >= 16'hCC00 && a <= 16'hCFFF) e.sel = S_CFG;
    else if (a >= 16'hC000 && a <= 16'hCBFF) e.sel = S_IO;
    else begin
      e.sel = S_MEM;
      if (a >= 16'hD000) begin
        e.addr = 17'h10000 + {1'b0, a};
      end else if (a <= 16'h8FFF) begin
        e.addr = (model_bank && !wr) ? 17'h10000 + {1'b0, a} : {1'b0, a};
        e.we = wr;
      end else begin
        e.addr = {1'b0, a};
        e.we = wr;
      end
    end
    return e;
  endfunction

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic rd,
                      input logic wr, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    q.push_back(model(a, rd, wr, tag));
    if (wr && a == 16'hC900) model_bank = d[0];
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      logic bad;
      e = q.pop_front();
      checks++;
      bad = (got_sel() !== e.sel) || (mem_we !== e.we) ||
            (e.sel == S_MEM && mem_addr !== e.addr);
      if (bad) begin
        errors++;
        $display("FAIL %s: got sel=%b we=%b addr=%h expected sel=%b we=%b addr=%h",
                 e.tag, got_sel(), mem_we, mem_addr, e.sel, e.we, e.addr);
      end
    end
  end

  task automatic run_tests();
    // R1: strobes active during reset, including a bank write
    cpu_addr = 16'hC900; cpu_wdata = 8'h01; cpu_wr = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (got_sel() !== 7'b0 || mem_we !== 1'b0 || mem_addr !== 17'h0) begin
      errors++;
      $display("FAIL R1: got sel=%b we=%b addr=%h expected sel=0000000 we=0 addr=00000",
               got_sel(), mem_we, mem_addr);
    end
    cpu_wr = 1'b0; rst = 1'b0;

    step(16'h1234, 8'h00, 1, 0, "R1 bank reset to RAM");
    step(16'h1234, 8'h00, 0, 0, "R2 idle");
    step(16'h9000, 8'h00, 1, 0, "R3 ram read low");
    step(16'hBFFF, 8'h00, 0, 1, "R3 ram write high");
    step(16'hD000, 8'h00, 1, 0, "R4 rom read low");
    step(16'hFFFF, 8'h00, 1, 0, "R4 rom read high");
    step(16'hE000, 8'h55, 0, 1, "R4 rom write no we");
    step(16'hC000, 8'h00, 1, 0, "R7 palette first");
    step(16'hC00F, 8'h00, 0, 1, "R7 palette last");
    step(16'hC010, 8'h00, 1, 0, "R8 after palette");
    step(16'hC803, 8'h00, 1, 0, "R8 before input");
    step(16'hC804, 8'h00, 1, 0, "R7 input first");
    step(16'hC807, 8'h00, 0, 1, "R7 input last");
    step(16'hC808, 8'h00, 1, 0, "R8 gap input sound");
    step(16'hC80C, 8'h00, 0, 1, "R7 sound first");
    step(16'hC80F, 8'h00, 1, 0, "R7 sound last");
    step(16'hC810, 8'h00, 1, 0, "R8 after sound");
    step(16'hCA00, 8'h00, 0, 1, "R7 blit first");
    step(16'hCA07, 8'h00, 1, 0, "R7 blit last");
    step(16'hCA08, 8'h00, 0, 1, "R9 after blit no we");
    step(16'hCBFF, 8'h00, 0, 1, "R8 io top");
    step(16'hCC00, 8'h00, 0, 1, "R7 cfg first");
    step(16'hCFFF, 8'h00, 1, 0, "R7 cfg last");
    step(16'h0100, 8'h00, 1, 0, "R5 bank0 read");
    step(16'hC900, 8'h01, 0, 1, "R9 bank write is io");
    step(16'h0000, 8'h00, 1, 0, "R5 bank1 read low");
    step(16'h8FFF, 8'h00, 1, 0, "R5 bank1 read high");
    step(16'h9000, 8'h00, 1, 0, "R3 unaffected by bank");
    step(16'h4321, 8'h00, 0, 1, "R6 write under rom");
    step(16'h4321, 8'h00, 1, 0, "R5 read after write");
    step(16'hC901, 8'h00, 0, 1, "R10 near address write");
    step(16'h0100, 8'h00, 1, 0, "R10 flag kept 1");
    step(16'hC900, 8'h00, 1, 0, "R10 read of ctrl");
    step(16'h0200, 8'h00, 1, 0, "R10 flag kept after read");
    step(16'hC900, 8'hFE, 0, 1, "R10 bit0 clears");
    step(16'h0100, 8'h00, 1, 0, "R5 back to ram");
    step(16'h8FFF, 8'h00, 0, 1, "R6 write bank0");
    step(16'h0000, 8'h00, 0, 0, "R2 final idle");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule